// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block sits on the host side of a NOR-style flash device. After the host has issued a program or erase command, it uses this controller to find out when the device's embedded operation has finished and whether it worked. The controller does this by reading the device's status byte over and over. A single start pulse supplies three things: the address to poll, the byte that was written (its top bit is the reference for data polling), and a mode bit. The mode bit chooses between two methods. One judges completion from the polling bit. The other judges it from the toggle bit alternating between reads.

Each status read is a single-word request on a request/acknowledge read port. The controller judges every returned byte as it arrives. When the device raises its error bit, the controller does not fail at once. It performs the confirming re-reads that the method calls for, and only then decides. A programmable read budget ends the poll with a timeout, so a device that never answers sensibly cannot hang the controller. The result is a one-cycle done pulse together with exactly one of pass, fail or timeout. That flag is held until the next accepted start.

Sending the reset command that a failed device needs is left to the host.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset, `rd_req_o`, `busy_o`, `done_o`, `pass_o`, `fail_o` and `timeout_o` are all low.
- R2: A start is accepted only while the controller is idle. A start that arrives while it is busy has no effect on the outcome or on the read address. Every read request carries the address captured at the accepted start. `rd_req_o` stays high until the cycle in which `rd_ack_i` is high, and `rd_data_i` is taken in that cycle.
- R3: In data-polling mode, a status byte whose bit 7 equals bit 7 of the expected byte ends the poll with pass. This holds even when bit 5 is also set, and all other bits are ignored.
- R4: In data-polling mode, a byte whose bit 7 differs from the expected bit 7 while bit 5 is 0 causes another read.
- R5: In data-polling mode, a byte whose bit 7 differs while bit 5 is 1 causes exactly one more read. If that read's bit 7 matches, the result is pass; otherwise it is fail.
- R6: In toggle mode, the first read only sets the reference value. Any later read whose bit 6 equals bit 6 of the read before it ends the poll with pass, even if bit 5 is 1.
- R7: In toggle mode, a read whose bit 6 differs from the previous read while bit 5 is 0 causes another read. The next comparison is made against this newest value.
- R8: In toggle mode, a read whose bit 6 differs while bit 5 is 1 causes exactly two more reads. If their bit 6 values are equal, the result is pass; if they differ, the result is fail.
- R9: Reads are counted from the accepted start. If read number max(limit, 1) gives no verdict, the poll ends with timeout. A verdict reached on that same read takes precedence over the timeout.
- R10: `done_o` is high for exactly one cycle: the cycle after the clock edge on which the deciding byte is acknowledged. From that edge on, exactly one of `pass_o`, `fail_o` and `timeout_o` is high. They hold their values until the next accepted start clears them, and no further read is requested.
- R11: `mode_i` = 0 selects data polling and `mode_i` = 1 selects toggle polling. The mode is captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a poll (accepted only when idle) |
| mode_i | input | 1 | 0 selects data polling, 1 selects toggle polling |
| addr_i | input | ADDR_W | Address to poll |
| exp_data_i | input | DATA_W | Byte that was written; bit 7 is the data-polling reference |
| max_reads_i | input | CNT_W | Read budget (0 behaves as 1) |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge; data is valid in this cycle |
| rd_data_i | input | DATA_W | Status byte returned by the device |
| busy_o | output | 1 | A poll is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation completed successfully |
| fail_o | output | 1 | Operation reported an error that the re-reads confirmed |
| timeout_o | output | 1 | Read budget used up without a verdict |

## Verification
The bench builds the controller with an 8-bit address and a 4-bit read budget. A 4-bit budget lets the sweep walk every limit from 0 up past the longest scripted sequence, so it reaches every case: timeout before the verdict read, timeout exactly on it, and verdict with budget to spare. For both modes, the sweep covers 0 to 3 busy reads, every ending (clean, error-then-good, error-then-bad, error bit set on an already-good read) and both reference polarities. From these parameters the bench works out the verdict and the number of reads arithmetically. Each scripted status byte has unrelated filler in its other bits, and some runs get a stray start mid-poll.

// File: rtl/fpc_pkg.sv
// Package: shared constants and types for the flash completion polling controller.
// Assumes the device status byte sits in the low eight bits of the read data.
package fpc_pkg;
    localparam int unsigned POLL_BIT   = 7;
    localparam int unsigned TOGGLE_BIT = 6;
    localparam int unsigned ERR_BIT    = 5;

    typedef enum logic [1:0] {
        VERD_NONE = 2'd0,
        VERD_PASS = 2'd1,
        VERD_FAIL = 2'd2
    } verdict_e;

    typedef enum logic [2:0] {
        PH_DP_RUN   = 3'd0,
        PH_DP_RECHK = 3'd1,
        PH_TG_FIRST = 3'd2,
        PH_TG_RUN   = 3'd3,
        PH_TG_ERR_A = 3'd4,
        PH_TG_ERR_B = 3'd5
    } phase_e;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_POLL = 1'b1
    } ctl_e;

    typedef struct packed {
        logic pass;
        logic fail;
        logic tmo;
    } outcome_t;
endpackage

// File: rtl/fpc_read_port.sv
// Read port: holds one single-word request open until it is acknowledged,
// and hands the acknowledged data to the judge in that same cycle.
// Assumes the address is constant for a whole poll (it is loaded at start).
module fpc_read_port #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              launch_i,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o
);
    logic              req_q;
    logic [ADDR_W-1:0] addr_q;

    // Request flag: set by a launch, cleared by the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= launch_i | (req_q & ~rd_ack_i);
        end
    end

    // Address register: captured once, at the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= load_addr_i;
        end
    end

    assign rd_req_o    = req_q;
    assign rd_addr_o   = addr_q;
    assign rsp_valid_o = req_q & rd_ack_i;
    assign rsp_data_o  = rd_data_i;

    // R2: an open request is neither dropped nor retargeted before its acknowledge
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !rd_ack_i) |=> (req_q && $stable(addr_q)));
endmodule

// File: rtl/fpc_read_budget.sv
// Read budget: counts the reads finished since start and reports when the
// read now being judged is the last one allowed. A limit of zero allows one read.
module fpc_read_budget #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             tick_i,
    output logic             exhausted_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc     = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign exhausted_o = tick_i && (cnt_inc >= {1'b0, lim_q});

    // Counter and limit: reloaded on start, advanced on every finished read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
            lim_q <= limit_i;
        end else if (tick_i) begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    // R9: the count never passes the effective limit
    a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_q == '0) ? (cnt_q <= 1) : (cnt_q <= lim_q));
endmodule

// File: rtl/fpc_judge.sv
// Judge: looks at each returned status byte and decides pass, fail or
// continue, following the data-polling or toggle-bit method.
// Assumes clear_i never coincides with rsp_valid_i.
module fpc_judge
    import fpc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              mode_i,
    input  logic              exp_bit_i,
    input  logic              rsp_valid_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    output verdict_e          verdict_o
);
    phase_e phase_q, phase_d;
    logic   prev_q, prev_d;
    logic   b_poll, b_tog, b_err;
    logic   unused_bits;

    assign b_poll      = rsp_data_i[POLL_BIT];
    assign b_tog       = rsp_data_i[TOGGLE_BIT];
    assign b_err       = rsp_data_i[ERR_BIT];
    assign unused_bits = ^rsp_data_i;

    // Decision logic for one acknowledged byte.
    always_comb begin
        phase_d   = phase_q;
        prev_d    = prev_q;
        verdict_o = VERD_NONE;
        if (rsp_valid_i) begin
            unique case (phase_q)
                PH_DP_RUN: begin
                    if (b_poll == exp_bit_i) begin
                        verdict_o = VERD_PASS;
                    end else if (b_err) begin
                        phase_d = PH_DP_RECHK;
                    end
                end
                PH_DP_RECHK: begin
                    verdict_o = (b_poll == exp_bit_i) ? VERD_PASS : VERD_FAIL;
                end
                PH_TG_FIRST: begin
                    prev_d  = b_tog;
                    phase_d = PH_TG_RUN;
                end
                PH_TG_RUN: begin
                    if (b_tog == prev_q) begin
                        verdict_o = VERD_PASS;
                    end else if (b_err) begin
                        phase_d = PH_TG_ERR_A;
                    end else begin
                        prev_d = b_tog;
                    end
                end
                PH_TG_ERR_A: begin
                    prev_d  = b_tog;
                    phase_d = PH_TG_ERR_B;
                end
                PH_TG_ERR_B: begin
                    verdict_o = (b_tog == prev_q) ? VERD_PASS : VERD_FAIL;
                end
                default: begin
                    phase_d = PH_DP_RUN;
                end
            endcase
        end
    end

    // Phase and reference bit: initialised per mode at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_DP_RUN;
            prev_q  <= 1'b0;
        end else if (clear_i) begin
            phase_q <= mode_i ? PH_TG_FIRST : PH_DP_RUN;
            prev_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            prev_q  <= prev_d;
        end
    end

    // R5 R8: a fail can only come from a confirming re-read after the error bit
    a_r5_fail_after_recheck: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && verdict_o == VERD_FAIL) |->
            (phase_q == PH_DP_RECHK || phase_q == PH_TG_ERR_B));

    // R6: the toggle reference read never decides on its own
    a_r6_first_read_sets_reference: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_i && phase_q == PH_TG_FIRST) |=> (phase_q == PH_TG_RUN));
endmodule

// File: rtl/flash_poll_ctrl.sv
// Flash completion polling controller (top).
// It accepts a start when idle, issues status reads through the read port,
// has each byte judged, and stops on a verdict or when the read budget runs out.
// Assumes the device acknowledges each request eventually; the budget bounds the reads.
module flash_poll_ctrl
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] exp_data_i,
    input  logic [CNT_W-1:0]  max_reads_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              fail_o,
    output logic              timeout_o
);
    ctl_e              state_q;
    outcome_t          out_q;
    logic              done_q;
    logic              exp_bit_q;
    logic              accept;
    logic              launch;
    logic              finish;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic              exhausted;
    verdict_e          verdict;
    logic              unused_exp;

    assign unused_exp = ^exp_data_i;
    assign accept     = start_i && (state_q == CTL_IDLE);
    assign finish     = rsp_valid && ((verdict != VERD_NONE) || exhausted);
    assign launch     = accept || (rsp_valid && !finish);

    fpc_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .load_addr_i (addr_i),
        .launch_i    (launch),
        .rd_ack_i    (rd_ack_i),
        .rd_data_i   (rd_data_i),
        .rd_req_o    (rd_req_o),
        .rd_addr_o   (rd_addr_o),
        .rsp_valid_o (rsp_valid),
        .rsp_data_o  (rsp_data)
    );

    fpc_judge #(.DATA_W(DATA_W)) u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (accept),
        .mode_i      (mode_i),
        .exp_bit_i   (exp_bit_q),
        .rsp_valid_i (rsp_valid),
        .rsp_data_i  (rsp_data),
        .verdict_o   (verdict)
    );

    fpc_read_budget #(.CNT_W(CNT_W)) u_budget (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (accept),
        .limit_i     (max_reads_i),
        .tick_i      (rsp_valid),
        .exhausted_o (exhausted)
    );

    // Control state: idle until an accepted start, polling until a finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTL_IDLE;
        end else if (accept) begin
            state_q <= CTL_POLL;
        end else if (finish) begin
            state_q <= CTL_IDLE;
        end
    end

    // Reference bit: latched from the expected byte at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_bit_q <= 1'b0;
        end else if (accept) begin
            exp_bit_q <= exp_data_i[POLL_BIT];
        end
    end

    // Outcome flags and done pulse: cleared at start, set once at finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                out_q <= '0;
            end else if (finish) begin
                out_q.pass <= (verdict == VERD_PASS);
                out_q.fail <= (verdict == VERD_FAIL);
                out_q.tmo  <= (verdict == VERD_NONE);
            end
        end
    end

    assign busy_o    = (state_q == CTL_POLL);
    assign done_o    = done_q;
    assign pass_o    = out_q.pass;
    assign fail_o    = out_q.fail;
    assign timeout_o = out_q.tmo;

    // R10: the outcome flags never overlap
    a_r10_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pass_o, fail_o, timeout_o}));

    // R10: done lasts exactly one cycle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: done always comes with exactly one outcome and no open request
    a_r10_done_has_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones({pass_o, fail_o, timeout_o}) == 1 && !rd_req_o));

    // R10: outcomes hold while idle until a new start arrives
    a_r10_outcome_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable({pass_o, fail_o, timeout_o}));

    // R1: no read is requested while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !rd_req_o);
endmodule

// File: tb/flash_poll_ctrl_tb.sv
// Bench: sweeps scripted status sequences in both modes over every small read
// budget and checks the verdict, read count and done pulse against arithmetic.
module flash_poll_ctrl_tb;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mode_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] exp_data_i = '0;
    logic [CW-1:0] max_reads_i = '0;
    logic          rd_req_o;
    logic [AW-1:0] rd_addr_o;
    logic          rd_ack_i = 1'b0;
    logic [DW-1:0] rd_data_i = '0;
    logic          busy_o, done_o, pass_o, fail_o, timeout_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int idx = 0;
    int nreads = 0;
    logic [AW-1:0] cur_addr = '0;
    logic [7:0] script [0:15];

    always #2.5 clk = ~clk;

    flash_poll_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .addr_i(addr_i), .exp_data_i(exp_data_i), .max_reads_i(max_reads_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
        .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o),
        .pass_o(pass_o), .fail_o(fail_o), .timeout_o(timeout_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Device model: answers each request one cycle later with the next scripted byte.
    always @(negedge clk) begin
        if (!rst_n) begin
            rd_ack_i = 1'b0;
        end else if (rd_ack_i) begin
            rd_ack_i = 1'b0;
        end else if (rd_req_o) begin
            rd_ack_i  = 1'b1;
            rd_data_i = script[idx];
            if (idx < 15) idx++;
            nreads++;
            check(rd_addr_o == cur_addr, "R2 read address", int'(rd_addr_o), int'(cur_addr));
        end
    end

    // Watchdog: a hung run is a failed check and still reaches the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    function automatic logic [7:0] filler(input int n);
        return 8'((n * 29) + 11);
    endfunction

    // Run one poll; vexp 0 pass, 1 fail, 2 timeout.
    task automatic run(input bit md, input int lim, input int need, input int vexp_v,
                       input bit inject, input string tag);
        int le, rexp, vexp, cyc;
        le   = (lim == 0) ? 1 : lim;
        rexp = (le < need) ? le : need;
        vexp = (le < need) ? 2 : vexp_v;
        idx = 0;
        nreads = 0;
        cur_addr = 8'((lim * 13) + need * 7 + 5);
        @(negedge clk);
        mode_i = md;
        addr_i = cur_addr;
        max_reads_i = CW'(lim);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        if (inject) begin
            while (nreads < 1) @(negedge clk);
            start_i = 1'b1;
            mode_i = ~md;
            addr_i = ~cur_addr;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        check(done_o == 1'b1, {tag, " R10 done seen"}, int'(done_o), 1);
        check(pass_o == (vexp == 0) && fail_o == (vexp == 1) && timeout_o == (vexp == 2),
              {tag, (vexp == 2) ? " R9 outcome" : " outcome"},
              int'({pass_o, fail_o, timeout_o}), (vexp == 0) ? 4 : (vexp == 1) ? 2 : 1);
        check(nreads == rexp, {tag, " R9 reads used"}, nreads, rexp);
        @(negedge clk);
        check(!done_o && !rd_req_o, {tag, " R10 single pulse"}, int'({done_o, rd_req_o}), 0);
        repeat (3) @(negedge clk);
        check(pass_o == (vexp == 0) && fail_o == (vexp == 1) && timeout_o == (vexp == 2)
              && nreads == rexp, {tag, " R10 hold"}, int'({pass_o, fail_o, timeout_o}),
              (vexp == 0) ? 4 : (vexp == 1) ? 2 : 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({rd_req_o, busy_o, done_o, pass_o, fail_o, timeout_o} == 6'b0,
              "R1 reset state", int'({rd_req_o, busy_o, done_o, pass_o, fail_o, timeout_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({rd_req_o, busy_o, done_o} == 3'b0, "R1 after release",
              int'({rd_req_o, busy_o, done_o}), 0);

        // Data polling (mode 0, R11): k busy reads then one of four endings.
        for (int k = 0; k < 4; k++) begin
            for (int kind = 0; kind < 4; kind++) begin
                for (int e7 = 0; e7 < 2; e7++) begin
                    for (int lim = 0; lim < 7; lim++) begin
                        int need;
                        string tag;
                        need = (kind == 1 || kind == 2) ? k + 2 : k + 1;
                        exp_data_i = filler(k + kind) ^ 8'h80;
                        exp_data_i[7] = e7[0];
                        for (int i = 0; i < 16; i++) begin
                            logic [7:0] b;
                            b = filler(i + 3 * kind + lim);
                            b[7] = ~e7[0];
                            b[5] = 1'b0;
                            if (i == k) begin
                                b[7] = (kind == 0 || kind == 3) ? e7[0] : ~e7[0];
                                b[5] = (kind != 0);
                            end
                            if (i == k + 1 && (kind == 1 || kind == 2)) begin
                                b[7] = (kind == 1) ? e7[0] : ~e7[0];
                                b[5] = 1'b1;
                            end
                            script[i] = b;
                        end
                        tag = (kind == 0) ? "R3 R4 R11 data" :
                              (kind == 3) ? "R3 data err-set match" : "R5 data recheck";
                        run(1'b0, lim, need, (kind == 2) ? 1 : 0,
                            (k == 3 && lim == 6), tag);
                    end
                end
            end
        end

        // Toggle polling (mode 1, R11): t busy toggles then one of four endings.
        for (int t = 0; t < 4; t++) begin
            for (int kind = 0; kind < 4; kind++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int lim = 0; lim < 9; lim++) begin
                        int need;
                        logic v;
                        string tag;
                        need = (kind == 1 || kind == 2) ? t + 4 : t + 2;
                        v = s[0];
                        for (int i = 0; i < 16; i++) begin
                            logic [7:0] b;
                            b = filler(i * 3 + kind + t);
                            if (i > 0) v = ~v;
                            b[5] = 1'b0;
                            if (i == t + 1) begin
                                if (kind == 0 || kind == 3) v = ~v;
                                b[5] = (kind != 0);
                            end
                            if (i > t + 1 && i <= t + 3 && (kind == 1 || kind == 2)) begin
                                if (i == t + 3 && kind == 1) v = ~v;
                                b[5] = 1'b1;
                            end
                            b[6] = v;
                            script[i] = b;
                        end
                        tag = (kind == 0) ? "R6 R7 R11 toggle" :
                              (kind == 3) ? "R6 toggle err-set stable" : "R8 toggle recheck";
                        run(1'b1, lim, need, (kind == 2) ? 1 : 0,
                            (t == 3 && lim == 8), tag);
                    end
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule